// File: doc/BRIEF.md
# 32-bit Base Integer Instruction Decoder with Immediate Generator

This block takes one fixed-width 32-bit instruction word of the base integer instruction set each clock and turns it into the fields and control signals an execution stage needs. Register numbers and the opcode, function-code fields always come from the same bit positions. The instruction is sorted into its encoding format, and the immediate is rebuilt from the scattered bits that format uses and sign-extended to the data width.

Alongside the fields it produces an ALU operation select, a register-write enable and one-bit markers for load, store, branch and jump instructions. An opcode outside the supported set raises an illegal flag and silences every side-effecting control. All outputs are registered: the instruction present at a rising clock edge shows up on the outputs right after that edge. A synchronous active-high reset clears every output to zero.

Top module: `rv32_decoder`

## Requirements
- R1: While reset is high at a rising edge, every output becomes zero after that edge, whatever the instruction input holds.
- R2: One edge after an instruction is sampled, dst_idx = inst[11:7], src1_idx = inst[19:15], src2_idx = inst[24:20], opc = inst[6:0], fn3 = inst[14:12] and fn7 = inst[31:25], for every opcode; 0x015A04B3 yields 9, 20, 21, 0x33, 0 and 0.
- R3: fmt codes are 0 none, 1 register, 2 immediate, 3 store, 4 branch, 5 upper, 6 jump. Opcodes map as 0110011→1, 0010011/0000011/1100111→2, 0100011→3, 1100011→4, 0110111/0010111→5, 1101111→6.
- R4: For fmt 2 the immediate is inst[31:20] sign-extended, so its range is -2048 to 2047.
- R5: For fmt 3 the immediate is {inst[31:25], inst[11:7]} sign-extended.
- R6: For fmt 4 the immediate is {inst[31], inst[7], inst[30:25], inst[11:8], 0} sign-extended (13 bits, bit 0 always zero).
- R7: For fmt 5 the immediate is inst[31:12] in bits [31:12] with zeros in bits [11:0].
- R8: For fmt 6 the immediate is {inst[31], inst[19:12], inst[20], inst[30:21], 0} sign-extended (21 bits).
- R9: For opcodes 0110011 and 0010011, alu_sel follows fn3: 000 add(0)/sub(1), 001 sll(2), 010 slt(3), 011 sltu(4), 100 xor(5), 101 srl(6)/sra(7), 110 or(8), 111 and(9). Instruction bit 30 picks sub over add (register form only) and sra over srl (both forms).
- R10: Load, store, jal, jalr and auipc select add(0); lui selects pass-operand-B(10); branches select sub(1) when fn3[2]=0, slt(3) when fn3[2:1]=10, sltu(4) when fn3[2:1]=11.
- R11: wr_en is 1 for register, immediate ALU, load, jal, jalr, lui and auipc instructions, except that it is 0 whenever dst_idx is 0; it is 0 for store and branch.
- R12: is_ld, is_st, is_br and is_jmp mark loads, stores, branches and jal/jalr respectively; at most one is ever high.
- R13: An opcode not listed in R3 sets illegal=1 with fmt=0, imm=0, alu_sel=0, wr_en=0 and all four markers low; the fields of R2 are still extracted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inst | input | 32 | Instruction word to decode |
| dst_idx | output | 5 | Destination register number |
| src1_idx | output | 5 | First source register number |
| src2_idx | output | 5 | Second source register number |
| opc | output | 7 | Opcode field |
| fn3 | output | 3 | 3-bit function field |
| fn7 | output | 7 | 7-bit function field |
| fmt | output | 3 | Encoding format code |
| imm | output | 32 | Assembled, sign-extended immediate |
| alu_sel | output | 4 | ALU operation select |
| wr_en | output | 1 | Register write enable |
| is_ld | output | 1 | Load instruction |
| is_st | output | 1 | Store instruction |
| is_br | output | 1 | Branch instruction |
| is_jmp | output | 1 | jal or jalr instruction |
| illegal | output | 1 | Unsupported opcode |

## Verification
The bench builds the decoder with its defaults: a 32-bit instruction, a 32-bit data width and 5-bit register indices. At that width every immediate bit lands in a distinct output position, so the sign-extension boundary between the raw immediate and the replicated sign is visible for all five immediate layouts, including the extreme values -2048, 2047 and all-ones offsets. Random words over the nine supported opcodes plus random illegal opcodes cover every fn3/bit-30 combination for the ALU select and the x0 write suppression.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

  localparam int ILEN   = 32;
  localparam int OPC_W  = 7;
  localparam int FN3_W  = 3;
  localparam int FN7_W  = 7;

  localparam logic [OPC_W-1:0] OP_REG    = 7'b0110011;
  localparam logic [OPC_W-1:0] OP_IMM    = 7'b0010011;
  localparam logic [OPC_W-1:0] OP_LOAD   = 7'b0000011;
  localparam logic [OPC_W-1:0] OP_STORE  = 7'b0100011;
  localparam logic [OPC_W-1:0] OP_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OP_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OP_JALR   = 7'b1100111;
  localparam logic [OPC_W-1:0] OP_LUI    = 7'b0110111;
  localparam logic [OPC_W-1:0] OP_AUIPC  = 7'b0010111;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_R    = 3'd1,
    FMT_I    = 3'd2,
    FMT_S    = 3'd3,
    FMT_B    = 3'd4,
    FMT_U    = 3'd5,
    FMT_J    = 3'd6
  } fmt_e;

  typedef enum logic [3:0] {
    ALU_ADD   = 4'd0,
    ALU_SUB   = 4'd1,
    ALU_SLL   = 4'd2,
    ALU_SLT   = 4'd3,
    ALU_SLTU  = 4'd4,
    ALU_XOR   = 4'd5,
    ALU_SRL   = 4'd6,
    ALU_SRA   = 4'd7,
    ALU_OR    = 4'd8,
    ALU_AND   = 4'd9,
    ALU_PASSB = 4'd10
  } alu_e;

  typedef struct packed {
    fmt_e fmt;
    alu_e alu;
    logic wr;
    logic ld;
    logic st;
    logic br;
    logic jmp;
    logic bad;
  } ctrl_t;

endpackage

// File: rtl/rvdec_fields.sv
module rvdec_fields #(
  parameter int ILEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic [ILEN-1:0]   word,
  output logic [RIDX_W-1:0] rd,
  output logic [RIDX_W-1:0] rs1,
  output logic [RIDX_W-1:0] rs2,
  output logic [6:0]        opcode,
  output logic [2:0]        f3,
  output logic [6:0]        f7
);
  localparam int RD_LO  = 7;
  localparam int F3_LO  = RD_LO + RIDX_W;
  localparam int RS1_LO = F3_LO + 3;
  localparam int RS2_LO = RS1_LO + RIDX_W;
  localparam int F7_LO  = RS2_LO + RIDX_W;

  // Same positions for every format: no per-format selection needed.
  assign opcode = word[6:0];
  assign rd     = word[RD_LO  +: RIDX_W];
  assign f3     = word[F3_LO  +: 3];
  assign rs1    = word[RS1_LO +: RIDX_W];
  assign rs2    = word[RS2_LO +: RIDX_W];
  assign f7     = word[F7_LO  +: 7];
endmodule

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
  import rvdec_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] f3,
  input  logic       alt_bit,
  input  logic       rd_zero,
  output ctrl_t      ctrl
);
  // alt_bit is instruction bit 30 (bit 5 of the 7-bit function field).
  function automatic alu_e arith_sel(input logic [2:0] code, input logic alt,
                                     input logic reg_form);
    alu_e r;
    case (code)
      3'b000:  r = (reg_form && alt) ? ALU_SUB : ALU_ADD;
      3'b001:  r = ALU_SLL;
      3'b010:  r = ALU_SLT;
      3'b011:  r = ALU_SLTU;
      3'b100:  r = ALU_XOR;
      3'b101:  r = alt ? ALU_SRA : ALU_SRL;
      3'b110:  r = ALU_OR;
      default: r = ALU_AND;
    endcase
    return r;
  endfunction

  function automatic alu_e cmp_sel(input logic [2:0] code);
    alu_e r;
    if (!code[2])     r = ALU_SUB;
    else if (code[1]) r = ALU_SLTU;
    else              r = ALU_SLT;
    return r;
  endfunction

  always_comb begin
    ctrl     = '0;
    ctrl.fmt = FMT_NONE;
    ctrl.alu = ALU_ADD;
    case (opcode)
      OP_REG: begin
        ctrl.fmt = FMT_R;
        ctrl.alu = arith_sel(f3, alt_bit, 1'b1);
        ctrl.wr  = 1'b1;
      end
      OP_IMM: begin
        ctrl.fmt = FMT_I;
        ctrl.alu = arith_sel(f3, alt_bit, 1'b0);
        ctrl.wr  = 1'b1;
      end
      OP_LOAD: begin
        ctrl.fmt = FMT_I;
        ctrl.wr  = 1'b1;
        ctrl.ld  = 1'b1;
      end
      OP_STORE: begin
        ctrl.fmt = FMT_S;
        ctrl.st  = 1'b1;
      end
      OP_BRANCH: begin
        ctrl.fmt = FMT_B;
        ctrl.alu = cmp_sel(f3);
        ctrl.br  = 1'b1;
      end
      OP_JAL: begin
        ctrl.fmt = FMT_J;
        ctrl.wr  = 1'b1;
        ctrl.jmp = 1'b1;
      end
      OP_JALR: begin
        ctrl.fmt = FMT_I;
        ctrl.wr  = 1'b1;
        ctrl.jmp = 1'b1;
      end
      OP_LUI: begin
        ctrl.fmt = FMT_U;
        ctrl.alu = ALU_PASSB;
        ctrl.wr  = 1'b1;
      end
      OP_AUIPC: begin
        ctrl.fmt = FMT_U;
        ctrl.wr  = 1'b1;
      end
      default: ctrl.bad = 1'b1;
    endcase
    // x0 is hardwired to zero, so a write to it is dropped here.
    if (rd_zero) ctrl.wr = 1'b0;
  end
endmodule

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
  import rvdec_pkg::*;
#(
  parameter int ILEN = 32,
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:0] word,
  input  fmt_e            fmt,
  output logic [XLEN-1:0] imm
);
  localparam int I_W = 12;
  localparam int B_W = 13;
  localparam int U_W = 20;
  localparam int J_W = 21;
  localparam int U_LO = 12;

  logic [I_W-1:0] raw_i;
  logic [I_W-1:0] raw_s;
  logic [B_W-1:0] raw_b;
  logic [U_W-1:0] raw_u;
  logic [J_W-1:0] raw_j;
  logic           sgn;

  assign sgn   = word[ILEN-1];
  assign raw_i = word[31:20];
  assign raw_s = {word[31:25], word[11:7]};
  assign raw_b = {word[31], word[7], word[30:25], word[11:8], 1'b0};
  assign raw_u = word[31:12];
  assign raw_j = {word[31], word[19:12], word[20], word[30:21], 1'b0};

  always_comb begin
    case (fmt)
      FMT_I:   imm = {{(XLEN-I_W){sgn}}, raw_i};
      FMT_S:   imm = {{(XLEN-I_W){sgn}}, raw_s};
      FMT_B:   imm = {{(XLEN-B_W){sgn}}, raw_b};
      FMT_U:   imm = {{(XLEN-U_W-U_LO){sgn}}, raw_u, {U_LO{1'b0}}};
      FMT_J:   imm = {{(XLEN-J_W){sgn}}, raw_j};
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/rv32_decoder.sv
module rv32_decoder
  import rvdec_pkg::*;
#(
  parameter int ILEN   = 32,
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5,
  parameter int FMT_W  = 3,
  parameter int ALU_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ILEN-1:0]   inst,
  output logic [RIDX_W-1:0] dst_idx,
  output logic [RIDX_W-1:0] src1_idx,
  output logic [RIDX_W-1:0] src2_idx,
  output logic [6:0]        opc,
  output logic [2:0]        fn3,
  output logic [6:0]        fn7,
  output logic [FMT_W-1:0]  fmt,
  output logic [XLEN-1:0]   imm,
  output logic [ALU_W-1:0]  alu_sel,
  output logic              wr_en,
  output logic              is_ld,
  output logic              is_st,
  output logic              is_br,
  output logic              is_jmp,
  output logic              illegal
);
  localparam int ALT_BIT = 5;

  logic [RIDX_W-1:0] c_rd, c_rs1, c_rs2;
  logic [6:0]        c_opc, c_f7;
  logic [2:0]        c_f3;
  ctrl_t             c_ctrl;
  logic [XLEN-1:0]   c_imm;

  rvdec_fields #(.ILEN(ILEN), .RIDX_W(RIDX_W)) u_fields (
    .word(inst), .rd(c_rd), .rs1(c_rs1), .rs2(c_rs2),
    .opcode(c_opc), .f3(c_f3), .f7(c_f7)
  );

  rvdec_ctrl u_ctrl (
    .opcode(c_opc), .f3(c_f3), .alt_bit(c_f7[ALT_BIT]),
    .rd_zero(c_rd == '0), .ctrl(c_ctrl)
  );

  rvdec_immgen #(.ILEN(ILEN), .XLEN(XLEN)) u_imm (
    .word(inst), .fmt(c_ctrl.fmt), .imm(c_imm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dst_idx  <= '0;
      src1_idx <= '0;
      src2_idx <= '0;
      opc      <= '0;
      fn3      <= '0;
      fn7      <= '0;
      fmt      <= '0;
      imm      <= '0;
      alu_sel  <= '0;
      wr_en    <= 1'b0;
      is_ld    <= 1'b0;
      is_st    <= 1'b0;
      is_br    <= 1'b0;
      is_jmp   <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      dst_idx  <= c_rd;
      src1_idx <= c_rs1;
      src2_idx <= c_rs2;
      opc      <= c_opc;
      fn3      <= c_f3;
      fn7      <= c_f7;
      fmt      <= FMT_W'(c_ctrl.fmt);
      imm      <= c_imm;
      alu_sel  <= ALU_W'(c_ctrl.alu);
      wr_en    <= c_ctrl.wr;
      is_ld    <= c_ctrl.ld;
      is_st    <= c_ctrl.st;
      is_br    <= c_ctrl.br;
      is_jmp   <= c_ctrl.jmp;
      illegal  <= c_ctrl.bad;
    end
  end
endmodule

// File: rtl/rvdec_checker.sv
module rvdec_checker #(
  parameter int ILEN   = 32,
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [ILEN-1:0]   inst,
  input logic [RIDX_W-1:0] dst_idx,
  input logic [RIDX_W-1:0] src1_idx,
  input logic [RIDX_W-1:0] src2_idx,
  input logic [2:0]        fmt,
  input logic [XLEN-1:0]   imm,
  input logic [3:0]        alu_sel,
  input logic              wr_en,
  input logic              is_ld,
  input logic              is_st,
  input logic              is_br,
  input logic              is_jmp,
  input logic              illegal
);
  // Set once the previous edge sampled an instruction outside reset.
  logic live;
  always_ff @(posedge clk) live <= !rst;

  p_fields_r2: assert property (@(posedge clk) disable iff (rst)
    live |-> (dst_idx == $past(inst[11:7]) && src1_idx == $past(inst[19:15])
              && src2_idx == $past(inst[24:20])));

  p_sign_r4: assert property (@(posedge clk) disable iff (rst)
    (live && (fmt == 3'd2 || fmt == 3'd3 || fmt == 3'd4 || fmt == 3'd6))
      |-> imm[XLEN-1] == $past(inst[ILEN-1]));

  p_even_offset_r6: assert property (@(posedge clk) disable iff (rst)
    (fmt == 3'd4 || fmt == 3'd6) |-> imm[0] == 1'b0);

  p_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    fmt == 3'd5 |-> imm[11:0] == 12'd0);

  p_x0_nowrite_r11: assert property (@(posedge clk) disable iff (rst)
    dst_idx == '0 |-> !wr_en);

  p_one_marker_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({is_ld, is_st, is_br, is_jmp}));

  p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wr_en && imm == '0 && fmt == 3'd0 && alu_sel == 4'd0
                 && !is_ld && !is_st && !is_br && !is_jmp));
endmodule

bind rv32_decoder rvdec_checker #(.ILEN(ILEN), .XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst(rst), .inst(inst), .dst_idx(dst_idx), .src1_idx(src1_idx),
  .src2_idx(src2_idx), .fmt(fmt), .imm(imm), .alu_sel(alu_sel), .wr_en(wr_en),
  .is_ld(is_ld), .is_st(is_st), .is_br(is_br), .is_jmp(is_jmp), .illegal(illegal)
);

// File: tb/tb_rv32_decoder.sv
module tb_rv32_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inst = 32'h0;
  logic [4:0]  dst_idx, src1_idx, src2_idx;
  logic [6:0]  opc, fn7;
  logic [2:0]  fn3, fmt;
  logic [31:0] imm;
  logic [3:0]  alu_sel;
  logic        wr_en, is_ld, is_st, is_br, is_jmp, illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rv32_decoder dut (
    .clk(clk), .rst(rst), .inst(inst), .dst_idx(dst_idx), .src1_idx(src1_idx),
    .src2_idx(src2_idx), .opc(opc), .fn3(fn3), .fn7(fn7), .fmt(fmt), .imm(imm),
    .alu_sel(alu_sel), .wr_en(wr_en), .is_ld(is_ld), .is_st(is_st),
    .is_br(is_br), .is_jmp(is_jmp), .illegal(illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] arith_exp(input logic [2:0] f, input logic b30,
                                           input logic regf);
    case (f)
      3'd0: return (regf && b30) ? 4'd1 : 4'd0;
      3'd1: return 4'd2;
      3'd2: return 4'd3;
      3'd3: return 4'd4;
      3'd4: return 4'd5;
      3'd5: return b30 ? 4'd7 : 4'd6;
      3'd6: return 4'd8;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [31:0] sx(input logic [31:0] v, input int w);
    logic [31:0] m;
    m = 32'hFFFF_FFFF << w;
    return v[w-1] ? (v | m) : (v & ~m);
  endfunction

  task automatic check_word(input logic [31:0] w);
    logic [2:0]  e_fmt;
    logic [31:0] e_imm;
    logic [3:0]  e_alu;
    logic        e_wr, e_ld, e_st, e_br, e_jmp, e_bad;
    string       itag, atag;
    e_fmt = 0; e_imm = 0; e_alu = 0;
    e_wr = 0; e_ld = 0; e_st = 0; e_br = 0; e_jmp = 0; e_bad = 0;
    atag = "R10";
    case (w[6:0])
      7'b0110011: begin e_fmt = 1; e_alu = arith_exp(w[14:12], w[30], 1'b1); e_wr = 1; atag = "R9"; end
      7'b0010011: begin e_fmt = 2; e_alu = arith_exp(w[14:12], w[30], 1'b0); e_wr = 1; atag = "R9"; end
      7'b0000011: begin e_fmt = 2; e_wr = 1; e_ld = 1; end
      7'b0100011: begin e_fmt = 3; e_st = 1; end
      7'b1100011: begin
        e_fmt = 4; e_br = 1;
        e_alu = !w[14] ? 4'd1 : (w[13] ? 4'd4 : 4'd3);
      end
      7'b1101111: begin e_fmt = 6; e_wr = 1; e_jmp = 1; end
      7'b1100111: begin e_fmt = 2; e_wr = 1; e_jmp = 1; end
      7'b0110111: begin e_fmt = 5; e_wr = 1; e_alu = 4'd10; end
      7'b0010111: begin e_fmt = 5; e_wr = 1; end
      default: begin e_bad = 1; atag = "R13"; end
    endcase
    if (w[11:7] == 5'd0) e_wr = 0;
    case (e_fmt)
      3'd2: begin itag = "R4"; e_imm = sx({20'd0, w[31:20]}, 12); end
      3'd3: begin itag = "R5"; e_imm = sx({20'd0, w[31:25], w[11:7]}, 12); end
      3'd4: begin itag = "R6"; e_imm = sx({19'd0, w[31], w[7], w[30:25], w[11:8], 1'b0}, 13); end
      3'd5: begin itag = "R7"; e_imm = {w[31:12], 12'd0}; end
      3'd6: begin itag = "R8"; e_imm = sx({11'd0, w[31], w[19:12], w[20], w[30:21], 1'b0}, 21); end
      default: itag = "R13";
    endcase
    @(negedge clk) inst = w;
    @(negedge clk);
    chk("R2", "rd",   32'(dst_idx),  32'(w[11:7]));
    chk("R2", "rs1",  32'(src1_idx), 32'(w[19:15]));
    chk("R2", "rs2",  32'(src2_idx), 32'(w[24:20]));
    chk("R2", "opc",  32'(opc),      32'(w[6:0]));
    chk("R2", "fn3",  32'(fn3),      32'(w[14:12]));
    chk("R2", "fn7",  32'(fn7),      32'(w[31:25]));
    chk("R3", "fmt",  32'(fmt),      32'(e_fmt));
    chk(itag, "imm",  imm,           e_imm);
    chk(atag, "alu",  32'(alu_sel),  32'(e_alu));
    chk("R11", "wr",  32'(wr_en),    32'(e_wr));
    chk("R12", "markers", {28'd0, is_ld, is_st, is_br, is_jmp},
        {28'd0, e_ld, e_st, e_br, e_jmp});
    chk("R13", "illegal", 32'(illegal), 32'(e_bad));
  endtask

  task automatic check_reset_zero();
    chk("R1", "fields", {dst_idx, src1_idx, src2_idx, opc, fn3, fn7}, 32'd0);
    chk("R1", "imm", imm, 32'd0);
    chk("R1", "ctrl", {20'd0, fmt, alu_sel, wr_en, is_ld, is_st, is_br, is_jmp, illegal},
        32'd0);
  endtask

  initial begin
    logic [6:0] ops [9];
    void'($urandom(32'd20240517));
    ops = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011, 7'b1100011,
            7'b1101111, 7'b1100111, 7'b0110111, 7'b0010111};

    // R1: reset with a busy instruction word on the input
    inst = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check_reset_zero();
    rst = 1'b0;

    // R2: add x9,x20,x21
    check_word(32'h015A04B3);
    chk("R2", "add rd", 32'(dst_idx), 32'd9);
    chk("R2", "add rs1", 32'(src1_idx), 32'd20);
    chk("R2", "add rs2", 32'(src2_idx), 32'd21);
    chk("R9", "add alu", 32'(alu_sel), 32'd0);
    // R9: sub / srai / srli / addi with bit 30 set stays add
    check_word(32'h403100B3);
    chk("R9", "sub alu", 32'(alu_sel), 32'd1);
    check_word(32'h40335293);
    chk("R9", "srai alu", 32'(alu_sel), 32'd7);
    check_word(32'h00335293);
    chk("R9", "srli alu", 32'(alu_sel), 32'd6);
    check_word(32'h40308093);
    chk("R9", "addi bit30 alu", 32'(alu_sel), 32'd0);
    // R4: immediate extremes
    check_word(32'h80000093);
    chk("R4", "addi -2048", imm, 32'hFFFF_F800);
    check_word(32'h7FF00093);
    chk("R4", "addi 2047", imm, 32'h0000_07FF);
    // R11: destination x0
    check_word(32'h00100013);
    chk("R11", "x0 write", 32'(wr_en), 32'd0);
    // R5, R6, R7, R8 directed
    check_word(32'hFE532FA3);
    chk("R5", "sw -1", imm, 32'hFFFF_FFFF);
    check_word(32'hFE000FE3);
    chk("R6", "beq -2", imm, 32'hFFFF_FFFE);
    check_word(32'hFFFFF0B7);
    chk("R7", "lui", imm, 32'hFFFF_F000);
    chk("R10", "lui alu", 32'(alu_sel), 32'd10);
    check_word(32'hFFFFF0EF);
    chk("R8", "jal -2", imm, 32'hFFFF_FFFE);
    check_word(32'h7FFFF0EF);
    chk("R8", "jal max", imm, 32'h000F_FFFE);
    // R13: unsupported opcode
    check_word(32'h0000007F);
    chk("R13", "illegal", 32'(illegal), 32'd1);

    // Random mix of supported and random opcodes
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] w;
      w = $urandom();
      if (($urandom() % 8) != 0) w[6:0] = ops[$urandom() % 9];
      check_word(w);
    end

    // R1: reset again mid-run
    @(negedge clk) begin rst = 1'b1; inst = 32'h015A04B3; end
    @(negedge clk);
    check_reset_zero();
    rst = 1'b0;
    check_word(32'hFE000FE3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule